// File: doc/BRIEF.md
# Sample Memory Host Port Controller

This block lets a host processor reach an external byte-wide sample memory through a single data register, one byte per access. The host first programs a memory-type selector, a 16-bit start word and a 16-bit stop word. It then writes a control byte that picks host read or host write. After that, every read strobe or data-register write moves one byte between the host and the memory. An internal pointer walks upward from the start address, and each access ends on a registered port to a synchronous memory. The controller also converts a 16-bit limit word to a byte address, which a playback engine elsewhere in the chip consumes.

The 16-bit words become byte addresses through a shift that depends on the memory type. The stop address also gets every shifted-in low bit set to one, so one stop word covers a whole block. In read mode the two reads after setup are dummies. The pointer stops at the stop address, and an end flag reports it.

Three flags sit beside the data path:
- a ready flag, which dips for one cycle after each completed memory access;
- a sticky end flag, which the host clears with an input;
- a busy flag, which a start command sets and a reset command clears.

Top module: `smem_port_ctrl`

## Requirements
- R1: A register write of address 0x0 is the control byte. Bit 7 sets `flag_busy`. Bit 0 clears the stored mode bits and `flag_busy` and forces `flag_brdy` high, taking priority over bit 7. After a bit-0 write, data reads and writes touch no memory.
- R2: Register addresses are: 0x2 memory type (bits 1:0), 0x4/0x5 start word low/high, 0x6/0x7 stop word low/high, 0x8/0x9 limit word low/high. The shift is 2 for type 0 and 5 for types 1, 2 and 3. A start or limit byte address is the word shifted left. The stop byte address is the shifted word with all shifted-in bits set to one. The limit word resets to 0xFFFF, and all other words reset to 0.
- R3: A control byte with bit 5 set loads the pointer with the start byte address and arms two dummy reads. In host read mode (bits 7..5 = 001), each of the first two read strobes returns 0, issues no memory read and reloads the pointer with the start address.
- R4: After the dummies, a read strobe in host read mode reads the byte at the pointer, returns it and advances the pointer by one.
- R5: In host write mode (bits 7..5 = 011), a write of address 0x1 cancels any pending dummies and starts from the start address. Each write stores its byte at the pointer and advances the pointer by one.
- R6: When the pointer equals the stop byte address, a read or write performs no memory access and sets `flag_eos`; a read then returns 0. The stop address itself is never accessed.
- R7: `flag_eos` stays set until `clr_eos` is high at a clock edge where no new end condition occurs. A new end condition wins over a simultaneous clear.
- R8: `flag_brdy` is low for exactly the one cycle after each memory access is issued and high otherwise.
- R9: Outside the matching mode, a read strobe returns 0 and a data-register write is ignored. Neither issues a memory access or moves the pointer.
- R10: A read strobe in the same cycle as any register write is dropped: no memory access, no `rd_valid`, and no change to the pointer or dummy count.
- R11: `rd_valid` is high for one cycle, two clock edges after the edge that samples an accepted read strobe. `rd_data` is valid while `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write byte |
| data_rd | input | 1 | Data register read strobe |
| clr_eos | input | 1 | Clears the end flag |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 21 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |
| limit_addr | output | 21 | Converted limit byte address |
| flag_brdy | output | 1 | Ready flag |
| flag_eos | output | 1 | End flag |
| flag_busy | output | 1 | Busy flag |

## Verification
The bench runs four patterns through the data register:
- A narrow-shift write run up to its padded stop address shows whether the end test and the two-bit padding fall on the right byte.
- A read-back of that run shows whether the dummy reads return zeros and no memory data. The dummies come first, so the first real byte reads back as the first byte written.
- A wide-shift read sweep across a whole 32-byte block, with a read colliding with a register write and a stray write in the wrong mode, separates correct pointer advance from skipped or repeated bytes.
- A final pattern pairs an end hit with a simultaneous flag clear, and then issues accesses after a control reset, which separates set priority and mode clearing from their opposites.

// File: rtl/smp_pkg.sv
package smp_pkg;
    localparam int REG_W     = 16;
    localparam int DATA_W    = 8;
    localparam int RA_W      = 4;
    localparam int SH_NARROW = 2;
    localparam int SH_WIDE   = 5;
    localparam int ADDR_W    = REG_W + SH_WIDE;
    localparam int SKIP_W    = 2;
    localparam logic [SKIP_W-1:0] SKIP_INIT = 2'd2;

    typedef logic [ADDR_W-1:0] baddr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [RA_W-1:0] {
        RA_CTRL    = 4'h0,
        RA_DATA    = 4'h1,
        RA_MTYPE   = 4'h2,
        RA_START_L = 4'h4,
        RA_START_H = 4'h5,
        RA_STOP_L  = 4'h6,
        RA_STOP_H  = 4'h7,
        RA_LIM_L   = 4'h8,
        RA_LIM_H   = 4'h9
    } reg_sel_e;

    typedef struct packed {
        logic start;
        logic rec;
        logic ext;
    } mode_t;

    localparam mode_t PAT_HOST_RD = '{start: 1'b0, rec: 1'b0, ext: 1'b1};
    localparam mode_t PAT_HOST_WR = '{start: 1'b0, rec: 1'b1, ext: 1'b1};

    function automatic int unsigned type_shift(input logic [1:0] mtype);
        return (mtype == 2'd0) ? SH_NARROW : SH_WIDE;
    endfunction

    function automatic baddr_t scale_word(input logic [REG_W-1:0] word,
                                          input logic [1:0] mtype,
                                          input logic pad);
        baddr_t r;
        baddr_t ones;
        r    = baddr_t'(word) << type_shift(mtype);
        ones = (baddr_t'(1) << type_shift(mtype)) - baddr_t'(1);
        if (pad) r = r | ones;
        return r;
    endfunction
endpackage

// File: rtl/smp_addr_map.sv
module smp_addr_map
    import smp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_sel,
    input  byte_t             wr_byte,
    output baddr_t            start_b,
    output baddr_t            stop_b,
    output baddr_t            limit_b
);
    logic [REG_W-1:0] start_w, stop_w, limit_w;
    logic [1:0]       mtype_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_w <= '0;
            stop_w  <= '0;
            limit_w <= '1;
            mtype_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                RA_MTYPE:   mtype_q        <= wr_byte[1:0];
                RA_START_L: start_w[7:0]   <= wr_byte;
                RA_START_H: start_w[15:8]  <= wr_byte;
                RA_STOP_L:  stop_w[7:0]    <= wr_byte;
                RA_STOP_H:  stop_w[15:8]   <= wr_byte;
                RA_LIM_L:   limit_w[7:0]   <= wr_byte;
                RA_LIM_H:   limit_w[15:8]  <= wr_byte;
                default: ;
            endcase
        end
    end

    assign start_b = scale_word(start_w, mtype_q, 1'b0);
    assign stop_b  = scale_word(stop_w,  mtype_q, 1'b1);
    assign limit_b = scale_word(limit_w, mtype_q, 1'b0);
endmodule

// File: rtl/smp_flags.sv
module smp_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_busy,
    input  logic ctl_reset,
    input  logic access,
    input  logic end_hit,
    input  logic clr_eos,
    output logic brdy,
    output logic eos,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            brdy <= 1'b1;
            eos  <= 1'b0;
            busy <= 1'b0;
        end else begin
            brdy <= !access;
            if (end_hit)      eos <= 1'b1;
            else if (clr_eos) eos <= 1'b0;
            if (ctl_reset)     busy <= 1'b0;
            else if (set_busy) busy <= 1'b1;
        end
    end
endmodule

// File: rtl/smp_access_seq.sv
module smp_access_seq
    import smp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ctl_wr,
    input  logic   ctl_start,
    input  logic   ctl_rec,
    input  logic   ctl_ext,
    input  logic   ctl_reset,
    input  logic   dat_wr,
    input  byte_t  dat_byte,
    input  logic   rd_req,
    input  baddr_t start_b,
    input  baddr_t stop_b,
    input  byte_t  mem_rdata,
    output logic   mem_re,
    output logic   mem_we,
    output baddr_t mem_addr,
    output byte_t  mem_wdata,
    output logic   rd_valid,
    output byte_t  rd_data,
    output logic   access,
    output logic   end_hit
);
    mode_t             mode_q;
    baddr_t            ptr_q;
    logic [SKIP_W-1:0] skip_q;
    logic              pend_q, rv_real_q;
    logic              rd_mode, wr_mode, rd_go, wr_go, skipping;
    logic              rd_real, rd_end, wr_real, wr_end;
    baddr_t            wr_base;

    always_comb begin
        rd_mode  = (mode_q == PAT_HOST_RD);
        wr_mode  = (mode_q == PAT_HOST_WR);
        rd_go    = rd_req && rd_mode;
        wr_go    = dat_wr && wr_mode;
        skipping = (skip_q != '0);
        wr_base  = skipping ? start_b : ptr_q;
        rd_real  = rd_go && !skipping && (ptr_q != stop_b);
        rd_end   = rd_go && !skipping && (ptr_q == stop_b);
        wr_real  = wr_go && (wr_base != stop_b);
        wr_end   = wr_go && (wr_base == stop_b);
        access   = rd_real || wr_real;
        end_hit  = rd_end || wr_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            ptr_q     <= '0;
            skip_q    <= '0;
            mem_re    <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            pend_q    <= 1'b0;
            rd_valid  <= 1'b0;
            rv_real_q <= 1'b0;
        end else begin
            mem_re    <= rd_real;
            mem_we    <= wr_real;
            pend_q    <= rd_req;
            rd_valid  <= pend_q;
            rv_real_q <= mem_re;
            if (rd_real)      mem_addr <= ptr_q;
            else if (wr_real) mem_addr <= wr_base;
            if (wr_real) mem_wdata <= dat_byte;

            if (ctl_wr) begin
                if (ctl_reset) mode_q <= '0;
                else mode_q <= '{start: ctl_start, rec: ctl_rec, ext: ctl_ext};
                if (ctl_ext) begin
                    ptr_q  <= start_b;
                    skip_q <= SKIP_INIT;
                end
            end else if (rd_go) begin
                if (skipping) begin
                    skip_q <= skip_q - 1'b1;
                    ptr_q  <= start_b;
                end else if (rd_real) begin
                    ptr_q <= ptr_q + baddr_t'(1);
                end
            end else if (wr_go) begin
                skip_q <= '0;
                ptr_q  <= wr_real ? wr_base + baddr_t'(1) : wr_base;
            end
        end
    end

    assign rd_data = rv_real_q ? mem_rdata : '0;
endmodule

// File: rtl/smem_port_ctrl.sv
module smem_port_ctrl
    import smp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              data_rd,
    input  logic              clr_eos,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] limit_addr,
    output logic              flag_brdy,
    output logic              flag_eos,
    output logic              flag_busy
);
    logic   ctl_wr, dat_wr, rd_req, access, end_hit;
    baddr_t start_b, stop_b, limit_b;

    assign ctl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign dat_wr = reg_wr && (reg_addr == RA_DATA);
    assign rd_req = data_rd && !reg_wr;

    smp_addr_map u_map (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr), .wr_sel(reg_addr), .wr_byte(reg_wdata),
        .start_b(start_b), .stop_b(stop_b), .limit_b(limit_b)
    );

    smp_access_seq u_seq (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_start(reg_wdata[7]), .ctl_rec(reg_wdata[6]),
        .ctl_ext(reg_wdata[5]), .ctl_reset(reg_wdata[0]),
        .dat_wr(dat_wr), .dat_byte(reg_wdata), .rd_req(rd_req),
        .start_b(start_b), .stop_b(stop_b), .mem_rdata(mem_rdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .access(access), .end_hit(end_hit)
    );

    smp_flags u_flags (
        .clk(clk), .rst(rst),
        .set_busy(ctl_wr && reg_wdata[7]), .ctl_reset(ctl_wr && reg_wdata[0]),
        .access(access), .end_hit(end_hit), .clr_eos(clr_eos),
        .brdy(flag_brdy), .eos(flag_eos), .busy(flag_busy)
    );

    assign limit_addr = limit_b;
endmodule

// File: rtl/smem_port_chk.sv
module smem_port_chk
    import smp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              data_rd,
    input logic              clr_eos,
    input logic              rd_valid,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] stop_b,
    input logic              flag_brdy,
    input logic              flag_eos,
    input logic              flag_busy
);
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h0 && reg_wdata[7] && !reg_wdata[0]) |=> flag_busy); // R1
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h0 && reg_wdata[0]) |=> (!flag_busy && flag_brdy)); // R1
    AST_STOP_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> (mem_addr != stop_b)); // R6
    AST_EOS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_eos && !clr_eos) |=> flag_eos); // R7
    AST_BRDY_DIP: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> !flag_brdy); // R8
    AST_BRDY_BACK: assert property (@(posedge clk) disable iff (rst)
        !flag_brdy |=> flag_brdy); // R8
    AST_NO_RD_ON_WR: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> $past(data_rd && !reg_wr)); // R10
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !reg_wr) |-> ##2 rd_valid); // R11
endmodule

bind smem_port_ctrl smem_port_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .data_rd(data_rd), .clr_eos(clr_eos),
    .rd_valid(rd_valid), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .stop_b(stop_b), .flag_brdy(flag_brdy),
    .flag_eos(flag_eos), .flag_busy(flag_busy)
);

// File: tb/smem_port_ctrl_bench.sv
module smem_port_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        data_rd = 1'b0;
    logic        clr_eos = 1'b0;
    logic        rd_valid, mem_re, mem_we;
    logic [7:0]  rd_data, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [20:0] mem_addr, limit_addr;
    logic        flag_brdy, flag_eos, flag_busy;

    int tests = 0;
    int fails = 0;
    int re_count = 0;
    bit done = 1'b0;

    logic [7:0] mem [0:4095];
    logic [7:0]  exp_rd_q[$];
    string       exp_rd_tag[$];
    logic [20:0] exp_wa_q[$];
    logic [7:0]  exp_wd_q[$];

    always #10 clk = ~clk;

    smem_port_ctrl u_smem_port_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .data_rd(data_rd), .clr_eos(clr_eos),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .limit_addr(limit_addr),
        .flag_brdy(flag_brdy), .flag_eos(flag_eos), .flag_busy(flag_busy)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 3 + 17) & 255);
    endfunction

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    end

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_re) re_count++;
            if (rd_valid) begin
                if (exp_rd_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R11 unexpected rd_valid actual=%0h expected=none", rd_data);
                end else begin
                    check(exp_rd_tag.pop_front(), {24'd0, rd_data}, {24'd0, exp_rd_q.pop_front()});
                end
            end
            if (mem_we) begin
                if (exp_wa_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R9 unexpected write actual=%0h expected=none", mem_addr);
                end else begin
                    check("R5 write addr", {11'd0, mem_addr}, {11'd0, exp_wa_q.pop_front()});
                    check("R5 write data", {24'd0, mem_wdata}, {24'd0, exp_wd_q.pop_front()});
                end
            end
        end
    end

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic dread(input logic [7:0] exp, input string tag);
        exp_rd_q.push_back(exp); exp_rd_tag.push_back(tag);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic dwrite(input logic [7:0] d, input bit real_acc, input logic [20:0] a);
        if (real_acc) begin exp_wa_q.push_back(a); exp_wd_q.push_back(d); end
        wreg(4'h1, d);
    endtask

    task automatic clear_eos();
        @(negedge clk); clr_eos = 1'b1;
        @(negedge clk); clr_eos = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset brdy", flag_brdy, 1);
        check("R7 reset eos", flag_eos, 0);
        check("R1 reset busy", flag_busy, 0);
        check("R11 reset rd_valid", rd_valid, 0);
        check("R2 reset limit", limit_addr, 21'h03FFFC);

        // narrow shift write run: start 0x40, stop 0x43
        wreg(4'h2, 8'h00);
        wreg(4'h4, 8'h10); wreg(4'h5, 8'h00);
        wreg(4'h6, 8'h10); wreg(4'h7, 8'h00);
        wreg(4'h0, 8'h60);
        dwrite(8'hA1, 1, 21'h40);
        check("R8 brdy dip", flag_brdy, 0);
        @(negedge clk);
        check("R8 brdy back", flag_brdy, 1);
        dwrite(8'hA2, 1, 21'h41);
        dwrite(8'hA3, 1, 21'h42);
        check("R6 no eos before stop", flag_eos, 0);
        dwrite(8'hA4, 0, 21'h0);
        check("R6 eos at stop write", flag_eos, 1);
        repeat (3) @(negedge clk);
        check("R7 eos sticky", flag_eos, 1);
        clear_eos();
        check("R7 eos cleared", flag_eos, 0);

        // read-back with dummies
        wreg(4'h0, 8'h20);
        base = re_count;
        dread(8'h00, "R3 dummy 1");
        dread(8'h00, "R3 dummy 2");
        drain();
        check("R3 no memory read on dummies", re_count - base, 0);
        dread(8'hA1, "R4 read 0x40");
        check("R8 brdy dip on read", flag_brdy, 0);
        dread(8'hA2, "R4 read 0x41");
        dread(8'hA3, "R4 read 0x42");
        dread(8'h00, "R6 read at stop");
        check("R6 eos at stop read", flag_eos, 1);
        drain();
        clear_eos();

        // wide shift sweep: start 0x60, stop 0x7F
        wreg(4'h2, 8'h01);
        wreg(4'h4, 8'h03);
        wreg(4'h6, 8'h03);
        wreg(4'h0, 8'h20);
        dread(8'h00, "R3 dummy wide 1");
        dread(8'h00, "R3 dummy wide 2");
        dread(pat(32'h60), "R2 first wide byte");
        exp_rd_q.push_back(8'h00); // placeholder removed below
        void'(exp_rd_q.pop_back());
        @(negedge clk); reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 8'h01; data_rd = 1'b1;
        @(negedge clk); reg_wr = 1'b0; data_rd = 1'b0;
        dread(pat(32'h61), "R10 pointer kept after dropped read");
        dwrite(8'h55, 0, 21'h0);
        for (int i = 2; i < 31; i++) dread(pat(32'h60 + i), "R4 wide sweep");
        check("R2 padded stop not reached early", flag_eos, 0);
        dread(8'h00, "R6 read at wide stop");
        check("R2 wide stop at 0x7F", flag_eos, 1);
        drain();

        // end hit together with clear: set wins
        @(negedge clk); data_rd = 1'b1; clr_eos = 1'b1;
        exp_rd_q.push_back(8'h00); exp_rd_tag.push_back("R6 repeat stop read");
        @(negedge clk); data_rd = 1'b0; clr_eos = 1'b0;
        check("R7 set wins over clear", flag_eos, 1);
        clear_eos();

        // limit conversion
        wreg(4'h8, 8'h03); wreg(4'h9, 8'h00);
        wreg(4'h2, 8'h02);
        check("R2 limit wide", limit_addr, 21'h60);
        wreg(4'h2, 8'h00);
        check("R2 limit narrow", limit_addr, 21'h0C);

        // start and reset commands
        wreg(4'h0, 8'h80);
        check("R1 busy on start", flag_busy, 1);
        wreg(4'h0, 8'h01);
        check("R1 busy cleared", flag_busy, 0);
        check("R1 brdy after reset cmd", flag_brdy, 1);
        base = re_count;
        dread(8'h00, "R9 read after reset cmd");
        dwrite(8'h77, 0, 21'h0);
        drain();
        check("R9 no memory read outside mode", re_count - base, 0);

        drain();
        check("R11 read queue drained", exp_rd_q.size(), 0);
        check("R5 write queue drained", exp_wa_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule